// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block is the serial control port of a tunable reference oscillator. It watches an open-drain two-wire bus through oversampled SCL and SDA inputs, and a fast system clock samples both lines. It responds to one 7-bit device address, and it pulls SDA low through an output-enable pin whenever it has to drive a zero. An external master uses it to set an output-divider value, a small control field and a signed frequency-offset byte. The master can also read back those registers and a 16-bit temperature word supplied by a neighbouring sensor.

A write transaction carries the device address with the write direction bit, then a register-address byte that loads the slave's pointer, then exactly one data byte. A read transaction returns the register the pointer selects, most significant bit first. The pointer keeps its value between transactions and never advances. The one exception is the temperature word: after its high byte the slave moves on to its low byte, so the master can stop after one byte or collect both. The temperature word is frozen at the start of each read, so the two bytes always come from the same sample.

The bus lines pass through two-flop synchronisers. The system clock must be at least 16 times the SCL rate. Every reaction of the slave is therefore three system clocks behind the bus edge that caused it.

Top module: `twi_tune_slave`

## Requirements
- R1: The device address is the 7-bit value 1,0,0,0,1,0 followed by the level of `addr_pin_i`, and the eighth bit of the byte is the direction bit (0 write, 1 read). A match is acknowledged by driving SDA low during the ninth clock, for either direction. A mismatch is not acknowledged, and the slave then ignores the bus until the next START.
- R2: START (SDA falling while SCL is high) aborts any transfer in progress and begins a new address phase. STOP (SDA rising while SCL is high) aborts any transfer in progress and returns the slave to idle. Both release SDA.
- R3: In a write, the register-address byte and the first data byte are each acknowledged. The data byte takes effect on the falling SCL edge that ends its eighth bit. Any further byte in the same write is neither acknowledged nor stored.
- R4: Writable registers, with their reset values: 5Dh is the divider select (8 bits, 00h). 60h is control (bits 3:0 stored, bits 7:4 read as 0, reset 0Ch; bit 0 half-duty select, bit 2 first output enable, bit 3 second output enable). 66h is the frequency offset (8-bit two's complement, 00h). Each is presented on its output port.
- R5: Addresses 64h and 65h hold the read-only temperature high and low bytes, and writes to them change nothing. Unmapped addresses read as 00h, and writes to them change nothing.
- R6: A read returns the register named by the last register-address byte received, MSB first. The pointer survives STOP and repeated START.
- R7: When the pointer is 64h, an acknowledged first byte is followed by the temperature low byte (65h), and further acknowledged bytes repeat the low byte. For any other pointer, each acknowledged byte repeats the same register.
- R8: The temperature word is captured when the read address phase ends. Both temperature bytes of one read come from that capture, even if `temp_i` changes later. A change on `temp_i` that arrives no later than the bus edge ending the address acknowledge is included in the capture.
- R9: After the master answers a read byte with NACK, SDA stays released until the next START.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: Out of reset, SDA is released, the registers hold their reset values and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pin_i | input | 1 | Strapped lowest device-address bit |
| temp_i | input | 16 | Current temperature word from the sensor |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| div_sel_o | output | 8 | Divider select register |
| ctrl_o | output | 4 | Control register bits 3:0 |
| offset_o | output | 8 | Frequency-offset register |

## Verification
Two functions can fall in the same clock: the temperature capture at the end of the address acknowledge, and an update of `temp_i`. The bench changes `temp_i` at the very instant it pulls SCL low after the address acknowledge. Both returned bytes must then carry the new word. The bench also changes `temp_i` again between the high and low byte, and the low byte must still belong to the captured word. Register outputs are compared on every clock against a behavioural model whose updates are timed three clocks after the bus edge.

// File: rtl/twi_tune_pkg.sv
// Shared types and constants of the two-wire tuning slave.
// Assumes 8-bit bus bytes and a 16-bit temperature word.
package twi_tune_pkg;
    localparam int BYTE_W = 8;
    localparam int TEMP_W = 16;
    localparam int CNT_W  = 4;

    localparam logic [5:0]        DEV_ID_HI  = 6'b100010;
    localparam logic [BYTE_W-1:0] RA_DIV     = 8'h5D;
    localparam logic [BYTE_W-1:0] RA_CTRL    = 8'h60;
    localparam logic [BYTE_W-1:0] RA_TEMP_HI = 8'h64;
    localparam logic [BYTE_W-1:0] RA_TEMP_LO = 8'h65;
    localparam logic [BYTE_W-1:0] RA_OFFSET  = 8'h66;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } link_state_e;
endpackage

// File: rtl/twi_tune_sync.sv
// Synchroniser bank for the bus lines.
// Each line passes through STAGES flops. A further flop gives the previous
// synchronised level, which the link uses for edge and condition detection.
// Assumes idle-high lines, so every flop resets to 1.
module twi_tune_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o,
    output logic [LINES-1:0] prev_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe_q;

        // Shift the raw level through the synchroniser and one history flop
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-1:0], raw_i[g]};
        end

        assign sync_o[g] = pipe_q[STAGES-1];
        assign prev_o[g] = pipe_q[STAGES];
    end
endmodule

// File: rtl/twi_tune_regs.sv
// Register bank behind the serial port.
// It holds the divider, control and offset registers and a frozen copy of the
// temperature word. A read while the copy is being loaded returns the
// incoming word, so the first byte of a read is already consistent with it.
module twi_tune_regs
    import twi_tune_pkg::*;
#(
    parameter int              CTRL_W   = 4,
    parameter logic [CTRL_W-1:0] CTRL_RST = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              snap_en,
    input  logic [TEMP_W-1:0] temp_i,
    output logic [BYTE_W-1:0] div_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] off_q
);
    logic [TEMP_W-1:0] snap_q;
    logic [TEMP_W-1:0] temp_view;

    // Register writes and temperature capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            ctrl_q <= CTRL_RST;
            off_q  <= '0;
            snap_q <= '0;
        end else begin
            if (snap_en) snap_q <= temp_i;
            if (wr_en) begin
                case (wr_addr)
                    RA_DIV:    div_q  <= wr_data;
                    RA_CTRL:   ctrl_q <= wr_data[CTRL_W-1:0];
                    RA_OFFSET: off_q  <= wr_data;
                    default:   ;
                endcase
            end
        end
    end

    // Read multiplexer, with the capture bypassed during its load cycle
    always_comb begin
        temp_view = snap_en ? temp_i : snap_q;
        case (rd_addr)
            RA_DIV:     rd_data = div_q;
            RA_CTRL:    rd_data = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
            RA_TEMP_HI: rd_data = temp_view[TEMP_W-1 -: BYTE_W];
            RA_TEMP_LO: rd_data = temp_view[BYTE_W-1:0];
            RA_OFFSET:  rd_data = off_q;
            default:    rd_data = '0;
        endcase
    end

    // R5: registers move only on a write strobe
    assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(div_q) && $stable(ctrl_q) && $stable(off_q)));

    // R4: a control write keeps exactly the stored bits of the data byte
    assert_ctrl_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_CTRL) |=> (ctrl_q == $past(wr_data[CTRL_W-1:0])));
endmodule

// File: rtl/twi_tune_link.sv
// Bus protocol engine of the two-wire slave.
// It detects START and STOP, shifts address and data bytes in on SCL rising,
// and changes its SDA drive on SCL falling. It keeps the register pointer.
// Assumes synchronised line levels plus their previous values, a clock at
// least 16x SCL, and an address pin that is static during a transaction.
module twi_tune_link
    import twi_tune_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    input  logic              addr_pin,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              snap_en,
    output logic              sda_oe
);
    link_state_e       state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] rptr;
    logic [BYTE_W-1:0] tx;
    logic              rw;
    logic              mack;
    logic              start_c, stop_c, scl_rise, scl_fall, byte_done, addr_ok;
    logic [BYTE_W-1:0] next_rptr;

    // Bus condition and edge decode from the synchronised levels
    always_comb begin
        start_c   = scl_s && scl_p && sda_p && !sda_s;
        stop_c    = scl_s && scl_p && !sda_p && sda_s;
        scl_rise  = scl_s && !scl_p;
        scl_fall  = !scl_s && scl_p;
        byte_done = scl_fall && (bitcnt == CNT_W'(BYTE_W));
        addr_ok   = (shreg[BYTE_W-1:1] == {DEV_ID_HI, addr_pin});
        next_rptr = (rptr == RA_TEMP_HI) ? RA_TEMP_LO : rptr;
    end

    // Register-side strobes and read address
    always_comb begin
        wr_en   = (state == ST_WDATA) && byte_done;
        wr_addr = ptr;
        wr_data = shreg;
        snap_en = (state == ST_ADDR_ACK) && scl_fall && rw;
        rd_addr = (state == ST_ADDR_ACK) ? ptr : next_rptr;
    end

    // Protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            ptr    <= '0;
            rptr   <= '0;
            tx     <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_c) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (stop_c) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && bitcnt != CNT_W'(BYTE_W)) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + CNT_W'(1);
                    end
                    if (byte_done) begin
                        bitcnt <= '0;
                        case (state)
                            ST_ADDR: begin
                                if (addr_ok) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state  <= ST_IDLE;
                                end
                            end
                            ST_PTR: begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                state  <= ST_PTR_ACK;
                            end
                            default: begin
                                sda_oe <= 1'b1;
                                state  <= ST_WDATA_ACK;
                            end
                        endcase
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            rptr   <= ptr;
                            tx     <= rd_data;
                            sda_oe <= !rd_data[BYTE_W-1];
                            bitcnt <= '0;
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_IDLE;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RDATA_ACK;
                        end else begin
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            sda_oe <= !tx[BYTE_W-2];
                            bitcnt <= bitcnt + CNT_W'(1);
                        end
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) mack <= !sda_s;
                    if (scl_fall) begin
                        if (mack) begin
                            rptr   <= next_rptr;
                            tx     <= rd_data;
                            sda_oe <= !rd_data[BYTE_W-1];
                            bitcnt <= '0;
                            state  <= ST_RDATA;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: the address acknowledge is only ever reached on a matching address
    assert_ack_only_on_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> addr_ok);

    // R2: STOP leaves the slave idle with SDA released
    assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (!sda_oe && state == ST_IDLE));

    // R9: SDA is free during the master's acknowledge slot of a read
    assert_master_ack_slot_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA_ACK) |-> !sda_oe);

    // R10: the drive changes only while the synchronised clock is low
    assert_drive_moves_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
endmodule

// File: rtl/twi_tune_slave.sv
// Top of the two-wire tuning slave: synchronisers, protocol engine and
// register bank. SDA is driven through an open-drain enable (1 = pull low).
// Assumes the system clock is at least 16x SCL.
module twi_tune_slave
    import twi_tune_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CTRL_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_pin_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] div_sel_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] offset_o
);
    logic [1:0]        line_s, line_p;
    logic              wr_en, snap_en;
    logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

    twi_tune_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .sync_o (line_s),
        .prev_o (line_p)
    );

    twi_tune_link link_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (line_s[0]),
        .scl_p    (line_p[0]),
        .sda_s    (line_s[1]),
        .sda_p    (line_p[1]),
        .addr_pin (addr_pin_i),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .snap_en  (snap_en),
        .sda_oe   (sda_oe_o)
    );

    twi_tune_regs #(.CTRL_W(CTRL_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .snap_en (snap_en),
        .temp_i  (temp_i),
        .div_q   (div_sel_o),
        .ctrl_q  (ctrl_o),
        .off_q   (offset_o)
    );
endmodule

// File: tb/twi_tune_slave_tb_top.sv
`timescale 1ns/1ps
module twi_tune_slave_tb_top;
    localparam int H = 20;  // half SCL period in system clocks

    logic        clk = 0;
    logic        rst_n = 0;
    logic        scl_m = 1, sda_m = 1;
    logic        addr_pin = 0;
    logic [15:0] temp_v = 16'h0000;
    logic        sda_oe;
    logic [7:0]  div_sel, offset;
    logic [3:0]  ctrl;
    logic        sda_line;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    bit cmp_on = 0;
    int exp_div = 0, exp_ctrl = 'hC, exp_off = 0;
    bit tswap_armed = 0;
    logic [15:0] tswap_val;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    twi_tune_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_pin_i(addr_pin), .temp_i(temp_v), .sda_oe_o(sda_oe),
        .div_sel_o(div_sel), .ctrl_o(ctrl), .offset_o(offset)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Per-clock comparison of the register outputs with the model (R4, R11)
    always begin
        @(posedge clk);
        #1;
        if (cmp_on) begin
            chk("R4 div", div_sel, exp_div);
            chk("R4 ctrl", ctrl, exp_ctrl);
            chk("R4 offset", offset, exp_off);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
        case (a)
            8'h5D: exp_div = d;
            8'h60: exp_ctrl = d & 8'h0F;
            8'h66: exp_off = d;
            default: ;
        endcase
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SCL pulse; also checks the slave drive is steady while SCL is high (R10)
    task automatic bus_bit(input logic b, output logic r);
        logic o1, o2;
        sda_m = b;
        wait_n(H);
        scl_m = 1;
        o1 = sda_oe;
        wait_n(H / 2);
        r = sda_line;
        wait_n(H / 2);
        o2 = sda_oe;
        chk("R10 drive steady while SCL high", o2, o1);
        scl_m = 0;
        if (tswap_armed) begin
            temp_v = tswap_val;
            tswap_armed = 0;
        end
    endtask

    task automatic bus_start();
        sda_m = 1; wait_n(H);
        scl_m = 1; wait_n(H);
        sda_m = 0; wait_n(H);
        scl_m = 0;
    endtask

    task automatic bus_stop();
        sda_m = 0; wait_n(H);
        scl_m = 1; wait_n(H);
        sda_m = 1; wait_n(H);
    endtask

    // mode 1: apply model write three clocks after the eighth falling edge
    // mode 2: swap temperature when SCL falls after the acknowledge bit
    task automatic send_byte(input logic [7:0] d, input int mode, input logic [7:0] wa,
                             output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
        if (mode == 1) begin
            repeat (3) @(posedge clk);
            model_write(wa, d);
            @(negedge clk);
        end
        if (mode == 2) tswap_armed = 1;
        bus_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            d[i] = r;
        end
        bus_bit(mack ? 1'b0 : 1'b1, r);
    endtask

    function automatic logic [7:0] dev(input bit a, input bit rd);
        return {6'b100010, a, rd};
    endfunction

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        bit k;
        bus_start();
        send_byte(dev(addr_pin, 0), 0, 0, k); chk("R1 write address ack", k, 1);
        send_byte(a, 0, 0, k);                chk("R3 pointer byte ack", k, 1);
        send_byte(d, 1, a, k);                chk("R3 data byte ack", k, 1);
        bus_stop();
    endtask

    // Sets the pointer, repeated START, reads n bytes (ACK all but the last)
    task automatic read_reg(input logic [7:0] a, input int n, input string tag,
                            input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2);
        bit k;
        logic [7:0] d;
        bus_start();
        send_byte(dev(addr_pin, 0), 0, 0, k); chk("R1 address ack", k, 1);
        send_byte(a, 0, 0, k);                chk("R6 pointer ack", k, 1);
        bus_start();
        send_byte(dev(addr_pin, 1), 0, 0, k); chk("R1 read address ack", k, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, d);
            chk(tag, d, (i == 0) ? e0 : ((i == 1) ? e1 : e2));
        end
        wait_n(10);
        chk("R9 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        bit k;
        logic r;
        logic [7:0] d;
        wait_n(6);
        rst_n = 1;
        wait_n(2);
        // R11 reset state
        chk("R11 SDA released", sda_oe, 0);
        chk("R11 div reset", div_sel, 0);
        chk("R11 ctrl reset", ctrl, 'hC);
        chk("R11 offset reset", offset, 0);
        cmp_on = 1;
        temp_v = 16'h1940;

        // R11 pointer 00h reads as unmapped zero
        bus_start();
        send_byte(dev(0, 1), 0, 0, k); chk("R1 read address ack", k, 1);
        read_byte(0, d); chk("R11 pointer reset reads 00", d, 0);
        bus_stop();

        // R3/R4/R6 write and read back each register
        write_reg(8'h5D, 8'hA5);
        read_reg(8'h5D, 1, "R6 divider read", 8'hA5, 0, 0);
        write_reg(8'h60, 8'hFF);
        read_reg(8'h60, 1, "R4 control upper bits zero", 8'h0F, 0, 0);
        write_reg(8'h66, 8'h9C);
        read_reg(8'h66, 1, "R6 offset read", 8'h9C, 0, 0);
        // R7 non-temperature pointer repeats the same register
        read_reg(8'h5D, 3, "R7 repeat same register", 8'hA5, 8'hA5, 8'hA5);

        // R5 writes to temperature and unmapped addresses are ignored
        write_reg(8'h64, 8'h55);
        write_reg(8'h70, 8'h33);
        read_reg(8'h70, 1, "R5 unmapped reads 00", 8'h00, 0, 0);
        read_reg(8'h64, 2, "R5 temperature unchanged by write", 8'h19, 8'h40, 0);

        // R3 a second data byte is neither acknowledged nor stored
        bus_start();
        send_byte(dev(0, 0), 0, 0, k); chk("R1 ack", k, 1);
        send_byte(8'h5D, 0, 0, k);     chk("R3 pointer ack", k, 1);
        send_byte(8'h11, 1, 8'h5D, k); chk("R3 first data ack", k, 1);
        send_byte(8'h22, 0, 0, k);     chk("R3 extra byte not acked", k, 0);
        bus_stop();
        chk("R3 extra byte not stored", div_sel, 8'h11);

        // R1 mismatching address: no ack, following bytes ignored
        bus_start();
        send_byte(dev(1, 0), 0, 0, k); chk("R1 mismatch not acked", k, 0);
        send_byte(8'h5D, 0, 0, k);     chk("R1 ignored after mismatch", k, 0);
        send_byte(8'h77, 0, 0, k);     chk("R1 ignored data byte", k, 0);
        bus_stop();
        chk("R1 register untouched after mismatch", div_sel, 8'h11);

        // R1 strapped bit selects the other address
        addr_pin = 1;
        wait_n(4);
        write_reg(8'h5D, 8'h3C);
        bus_start();
        send_byte(dev(0, 0), 0, 0, k); chk("R1 old address not acked", k, 0);
        bus_stop();
        addr_pin = 0;
        wait_n(4);

        // R7 temperature two-byte, three-byte and one-byte reads
        read_reg(8'h64, 2, "R7 temperature MSB then LSB", 8'h19, 8'h40, 0);
        read_reg(8'h64, 3, "R7 LSB repeats", 8'h19, 8'h40, 8'h40);
        read_reg(8'h64, 1, "R7 one-byte temperature", 8'h19, 0, 0);

        // R8 capture coincides with a temperature change; later change ignored
        temp_v = 16'hD880;
        bus_start();
        send_byte(dev(0, 0), 0, 0, k);
        send_byte(8'h64, 0, 0, k);
        bus_start();
        tswap_val = 16'h4B40;
        send_byte(dev(0, 1), 2, 0, k); chk("R1 read ack", k, 1);
        read_byte(1, d); chk("R8 MSB from capture", d, 8'h4B);
        temp_v = 16'hEC11;
        read_byte(0, d); chk("R8 LSB from same capture", d, 8'h40);
        bus_stop();

        // R2 STOP mid data byte aborts the write
        bus_start();
        send_byte(dev(0, 0), 0, 0, k);
        send_byte(8'h66, 0, 0, k);
        bus_bit(1, r); bus_bit(0, r); bus_bit(1, r);
        bus_stop();
        chk("R2 STOP abort leaves offset", offset, 8'h9C);
        chk("R2 STOP releases SDA", sda_oe, 0);

        // R2 repeated START mid data byte starts a new transfer (pointer kept, R6)
        bus_start();
        send_byte(dev(0, 0), 0, 0, k);
        send_byte(8'h60, 0, 0, k);
        bus_bit(0, r); bus_bit(1, r);
        bus_start();
        send_byte(dev(0, 1), 0, 0, k); chk("R2 repeated START address ack", k, 1);
        read_byte(0, d); chk("R2 read after repeated START", d, 8'h0F);
        bus_stop();
        chk("R2 control unchanged", ctrl, 4'hF);

        wait_n(20);
        finish_run();
    end
endmodule